// File: doc/BRIEF.md
# Configurable 1:4 Receive Deserializer

The block takes a recovered serial bit stream, one bit per rising edge of the recovered fast clock, and packs each group of four bits into a parallel word. A free-running bit counter marks the word boundaries; reset clears it, so the first edge after reset carries bit position 0. Each completed word moves to the output register one fast cycle after its fourth bit. That same edge raises a word clock that runs at one quarter of the bit rate.

A bit-order select decides whether the first bit received lands in the lowest or the highest lane. An active-low squelch forces the word to zero. An active-low loopback control replaces the line bit with a locally looped serial source, and while loopback is active the squelch is overridden.

An auxiliary clock runs either at the word rate or at one quarter of it, and a disable input holds it low. Its enable and divide settings are taken up only at the 16-bit-cycle divider boundary. As a result the auxiliary clock never emits a truncated pulse, and it always rises together with the word clock.

Top module: `rx_deser4`

## Requirements
- R1: `word_clk_o` has a period of 4 fast cycles: high for 2, low for 2. `word_o` changes only on a fast edge where `word_clk_o` rises, unless the squelch or loopback inputs change.
- R2: After reset release, the first fast edge captures bit position 0. The word built from edges 1 to 4 appears on `word_o` after edge 5, and each later word follows 4 edges after the one before.
- R3: With `msb_first_i` = 0, the first bit of a word goes to `word_o[0]`, the second to `word_o[1]`, the third to `word_o[2]` and the fourth to `word_o[3]`.
- R4: With `msb_first_i` = 1, the first bit of a word goes to `word_o[3]`, the second to `word_o[2]`, the third to `word_o[1]` and the fourth to `word_o[0]`.
- R5: While `sqlch_ni` = 0 and `lpbk_ni` = 1, `word_o` is all zeros in the same cycle.
- R6: While `lpbk_ni` = 0, `sqlch_ni` has no effect on `word_o`.
- R7: When `lpbk_ni` = 0 the captured bit is `lpbk_bit_i`; when `lpbk_ni` = 1 it is `line_bit_i`.
- R8: With the auxiliary clock enabled and `aux_div4_i` = 0, `aux_clk_o` equals `word_clk_o`.
- R9: With the auxiliary clock enabled and `aux_div4_i` = 1, `aux_clk_o` has a 16-cycle period. It is high for the 8 cycles that follow fast edges at divider positions 0 to 7, where the position is (edges since reset − 1) mod 16.
- R10: The values of `aux_off_i` and `aux_div4_i` are sampled only on the edge at divider position 15 and take effect from the next edge. While disabled, `aux_clk_o` is held low, and `aux_clk_o` rises only on an edge where `word_clk_o` rises.
- R11: `rst_ni` low asynchronously clears `word_o`, `word_clk_o` and `aux_clk_o`, and leaves the auxiliary clock disabled until the first divider boundary after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Recovered fast bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_bit_i | input | 1 | Serial bit from the line |
| lpbk_bit_i | input | 1 | Serial bit from the local loopback path |
| lpbk_ni | input | 1 | Loopback enable, active low |
| msb_first_i | input | 1 | Bit order select: 0 fills lane 0 first, 1 fills lane 3 first |
| sqlch_ni | input | 1 | Output squelch, active low |
| aux_div4_i | input | 1 | Auxiliary divide: 0 word rate, 1 quarter word rate |
| aux_off_i | input | 1 | Auxiliary clock disable, active high |
| word_o | output | WORD_W | Parallel output word |
| word_clk_o | output | 1 | Word clock, bit rate divided by WORD_W |
| aux_clk_o | output | 1 | Auxiliary clock |

## Verification
The bench sweeps all sixteen 4-bit patterns under both bit orders and all four combinations of squelch and loopback. On every word it drives the unselected serial source with the inverse of the intended bits, so a swapped or stuck source mux produces a complemented word instead of going unnoticed. A lane-order error shows up as a mirrored word, an off-by-one boundary as a word shifted by one bit, and a squelch that ignores loopback as zeros where data was expected. The auxiliary settings change every few words, out of step with the 16-cycle boundary. A design that applied them at once would show a short or misplaced auxiliary pulse on the cycle-by-cycle model.

// File: rtl/rx_deser4_pkg.sv
package rx_deser4_pkg;

  typedef struct packed {
    logic en;
    logic slow;
  } aux_cfg_t;

  localparam aux_cfg_t AUX_CFG_RST = '{en: 1'b0, slow: 1'b0};

endpackage

// File: rtl/rx_deser4_bitcnt.sv
module rx_deser4_bitcnt #(
  parameter int unsigned WORD_W = 4,
  localparam int unsigned CNT_W = $clog2(WORD_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o,
  output logic             word_clk_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             wclk_q;

  assign last_o     = (cnt_q == CNT_W'(WORD_W - 1));
  assign cnt_o      = cnt_q;
  assign word_clk_o = wclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      wclk_q <= 1'b0;
    end else begin
      cnt_q  <= last_o ? '0 : cnt_q + CNT_W'(1);
      // high in the first half of each word
      wclk_q <= (cnt_q < CNT_W'(WORD_W / 2));
    end
  end

endmodule

// File: rtl/rx_deser4_shift.sv
module rx_deser4_shift #(
  parameter int unsigned WORD_W = 4,
  localparam int unsigned CNT_W = $clog2(WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_i,
  input  logic              msb_first_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              last_i,
  input  logic              squelch_i,
  output logic [WORD_W-1:0] word_o
);

  logic [WORD_W-1:0] lanes;
  logic [WORD_W-1:0] word_q;
  logic              load_q;

  for (genvar g = 0; g < WORD_W; g++) begin : g_lane
    logic lane_q;
    logic take;
    assign take = msb_first_i ? (cnt_i == CNT_W'(WORD_W - 1 - g))
                              : (cnt_i == CNT_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   lane_q <= 1'b0;
      else if (take) lane_q <= bit_i;
    end
    assign lanes[g] = lane_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q <= 1'b0;
      word_q <= '0;
    end else begin
      load_q <= last_i;
      if (load_q) word_q <= lanes;
    end
  end

  assign word_o = squelch_i ? '0 : word_q;

endmodule

// File: rtl/rx_deser4_aux.sv
module rx_deser4_aux
  import rx_deser4_pkg::*;
#(
  parameter int unsigned WORD_W    = 4,
  parameter int unsigned AUX_WORDS = 4,
  localparam int unsigned CNT_W  = $clog2(WORD_W),
  localparam int unsigned WCNT_W = $clog2(AUX_WORDS),
  localparam int unsigned POS_W  = CNT_W + WCNT_W,
  localparam int unsigned SPAN   = WORD_W * AUX_WORDS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             last_i,
  input  logic             div_sel_i,
  input  logic             off_i,
  output logic             aux_clk_o
);

  logic [WCNT_W-1:0] wcnt_q;
  logic [POS_W-1:0]  pos;
  logic              boundary;
  logic              aux_d, aux_q;
  aux_cfg_t          cfg_q;

  assign pos      = {wcnt_q, cnt_i};
  assign boundary = (pos == POS_W'(SPAN - 1));

  always_comb begin
    if (cfg_q.slow) aux_d = cfg_q.en & (pos < POS_W'(SPAN / 2));
    else            aux_d = cfg_q.en & (cnt_i < CNT_W'(WORD_W / 2));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wcnt_q <= '0;
      cfg_q  <= AUX_CFG_RST;
      aux_q  <= 1'b0;
    end else begin
      if (last_i) wcnt_q <= wcnt_q + WCNT_W'(1);
      // settings only change where both divider phases end low
      if (boundary) cfg_q <= '{en: ~off_i, slow: div_sel_i};
      aux_q <= aux_d;
    end
  end

  assign aux_clk_o = aux_q;

endmodule

// File: rtl/rx_deser4.sv
module rx_deser4
  import rx_deser4_pkg::*;
#(
  parameter int unsigned WORD_W    = 4,
  parameter int unsigned AUX_WORDS = 4,
  localparam int unsigned CNT_W = $clog2(WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_bit_i,
  input  logic              lpbk_bit_i,
  input  logic              lpbk_ni,
  input  logic              msb_first_i,
  input  logic              sqlch_ni,
  input  logic              aux_div4_i,
  input  logic              aux_off_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_clk_o,
  output logic              aux_clk_o
);

  logic [CNT_W-1:0] cnt;
  logic             last;
  logic             ser_bit;
  logic             squelch;

  assign ser_bit = lpbk_ni ? line_bit_i : lpbk_bit_i;
  assign squelch = ~sqlch_ni & lpbk_ni;

  rx_deser4_bitcnt #(.WORD_W(WORD_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cnt_o      (cnt),
    .last_o     (last),
    .word_clk_o (word_clk_o)
  );

  rx_deser4_shift #(.WORD_W(WORD_W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bit_i       (ser_bit),
    .msb_first_i (msb_first_i),
    .cnt_i       (cnt),
    .last_i      (last),
    .squelch_i   (squelch),
    .word_o      (word_o)
  );

  rx_deser4_aux #(.WORD_W(WORD_W), .AUX_WORDS(AUX_WORDS)) u_aux (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cnt_i     (cnt),
    .last_i    (last),
    .div_sel_i (aux_div4_i),
    .off_i     (aux_off_i),
    .aux_clk_o (aux_clk_o)
  );

endmodule

// File: rtl/rx_deser4_chk.sv
module rx_deser4_chk #(
  parameter int unsigned WORD_W    = 4,
  parameter int unsigned AUX_WORDS = 4,
  localparam int unsigned SPAN  = WORD_W * AUX_WORDS,
  localparam int unsigned SNC_W = $clog2(WORD_W) + 1,
  localparam int unsigned RUN_W = $clog2(SPAN + 2) + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              lpbk_ni,
  input logic              sqlch_ni,
  input logic              aux_div4_i,
  input logic              aux_off_i,
  input logic [WORD_W-1:0] word_o,
  input logic              word_clk_o,
  input logic              aux_clk_o
);

  logic             wprev_q, seen_q;
  logic [SNC_W-1:0] since_q;
  logic [RUN_W-1:0] off_run_q, div1_run_q;
  logic             wrise;

  assign wrise = word_clk_o & ~wprev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wprev_q    <= 1'b0;
      seen_q     <= 1'b0;
      since_q    <= '0;
      off_run_q  <= '0;
      div1_run_q <= '0;
    end else begin
      wprev_q <= word_clk_o;
      if (wrise) begin
        seen_q  <= 1'b1;
        since_q <= '0;
      end else if (since_q != '1) begin
        since_q <= since_q + SNC_W'(1);
      end
      if (!aux_off_i) off_run_q <= '0;
      else if (off_run_q != RUN_W'(SPAN + 1)) off_run_q <= off_run_q + RUN_W'(1);
      if (aux_off_i || aux_div4_i) div1_run_q <= '0;
      else if (div1_run_q != RUN_W'(SPAN + 1)) div1_run_q <= div1_run_q + RUN_W'(1);
    end
  end

  AST_WCLK_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && wrise) |-> (since_q == SNC_W'(WORD_W - 1))); // R1
  AST_WCLK_DUTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(word_clk_o) |=> word_clk_o); // R1
  AST_WORD_AT_WCLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$rose(word_clk_o) && $stable(sqlch_ni) && $stable(lpbk_ni)) |-> $stable(word_o)); // R1
  AST_SQUELCH_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sqlch_ni && lpbk_ni) |-> (word_o == '0)); // R5
  AST_AUX_DIV1_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div1_run_q == RUN_W'(SPAN + 1)) |-> (aux_clk_o == word_clk_o)); // R8
  AST_AUX_OFF_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (off_run_q == RUN_W'(SPAN + 1)) |-> !aux_clk_o); // R10
  AST_AUX_RISE_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(aux_clk_o) |-> $rose(word_clk_o)); // R10

endmodule

bind rx_deser4 rx_deser4_chk #(.WORD_W(WORD_W), .AUX_WORDS(AUX_WORDS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .lpbk_ni    (lpbk_ni),
  .sqlch_ni   (sqlch_ni),
  .aux_div4_i (aux_div4_i),
  .aux_off_i  (aux_off_i),
  .word_o     (word_o),
  .word_clk_o (word_clk_o),
  .aux_clk_o  (aux_clk_o)
);

// File: tb/rx_deser4_bench.sv
`timescale 1ns/1ps
module rx_deser4_bench;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       line_bit_i, lpbk_bit_i, lpbk_ni, msb_first_i, sqlch_ni;
  logic       aux_div4_i, aux_off_i;
  logic [3:0] word_o;
  logic       word_clk_o, aux_clk_o;

  int  n_chk = 0;
  int  n_bad = 0;
  int  edges = 0;
  int  wi = 0;
  bit  done = 0;
  bit  cfg_en = 0, cfg_slow = 0;
  bit  have_prev = 0, first_word = 1;
  logic [3:0] prev_pat;
  bit  prev_ord, prev_lb;

  always #4 clk_i = ~clk_i;

  rx_deser4 u_rx_deser4 (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_bit_i(line_bit_i), .lpbk_bit_i(lpbk_bit_i),
    .lpbk_ni(lpbk_ni), .msb_first_i(msb_first_i), .sqlch_ni(sqlch_ni),
    .aux_div4_i(aux_div4_i), .aux_off_i(aux_off_i),
    .word_o(word_o), .word_clk_o(word_clk_o), .aux_clk_o(aux_clk_o)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h (edge %0d)", tag, got, exp, edges);
    end
  endtask

  function automatic logic [3:0] rev4(input logic [3:0] v);
    for (int i = 0; i < 4; i++) rev4[i] = v[3-i];
  endfunction

  // one fast edge, then checks of both clocks from the cycle model
  task automatic tick();
    int p;
    bit exp_aux;
    @(posedge clk_i);
    edges++;
    p = (edges - 1) % 16;
    exp_aux = cfg_en && (cfg_slow ? (p < 8) : ((p % 4) < 2));
    if (p == 15) begin
      cfg_en   = !aux_off_i;
      cfg_slow = aux_div4_i;
    end
    @(negedge clk_i);
    chk("R1 word clock", word_clk_o, ((p % 4) < 2));
    chk(cfg_slow && cfg_en ? "R9 aux slow" : (cfg_en ? "R8 aux fast" : "R10 aux off/boundary"),
        aux_clk_o, exp_aux);
  endtask

  task automatic send_word(input logic [3:0] pat, input bit ord, input bit lb, input bit sq);
    logic [3:0] exp;
    for (int k = 0; k < 4; k++) begin
      msb_first_i = ord;
      lpbk_ni     = lb;
      sqlch_ni    = sq;
      line_bit_i  = lb ? pat[k] : ~pat[k];
      lpbk_bit_i  = lb ? ~pat[k] : pat[k];
      aux_off_i   = ((wi / 5) % 4) == 3;
      aux_div4_i  = ((wi / 7) % 2) == 1;
      tick();
      if (k == 0 && have_prev) begin
        exp = prev_ord ? rev4(prev_pat) : prev_pat;
        if (!sq && lb)            chk("R5 squelch zero", word_o, 4'h0);
        else if (!sq && !lb)      chk("R6 squelch ignored in loopback", word_o, exp);
        else if (first_word)      chk("R2 first word alignment", word_o, exp);
        else if (!prev_lb)        chk("R7 loopback source", word_o, exp);
        else if (prev_ord)        chk("R4 reversed order", word_o, exp);
        else                      chk("R3 natural order", word_o, exp);
        first_word = 0;
      end
    end
    prev_pat = pat; prev_ord = ord; prev_lb = lb; have_prev = 1;
    wi++;
  endtask

  initial begin
    rst_ni = 1'b0;
    line_bit_i = 0; lpbk_bit_i = 0; lpbk_ni = 1; msb_first_i = 0;
    sqlch_ni = 1; aux_div4_i = 0; aux_off_i = 0;
    repeat (3) @(negedge clk_i);
    chk("R11 reset word", word_o, 4'h0);
    chk("R11 reset word clock", word_clk_o, 1'b0);
    chk("R11 reset aux clock", aux_clk_o, 1'b0);
    rst_ni = 1'b1;
    for (int lb = 1; lb >= 0; lb--)
      for (int sq = 1; sq >= 0; sq--)
        for (int ord = 0; ord < 2; ord++)
          for (int pat = 0; pat < 16; pat++)
            send_word(4'(pat), ord[0], lb[0], sq[0]);
    send_word(4'h5, 1'b0, 1'b1, 1'b1);
    rst_ni = 1'b0;
    #1;
    chk("R11 async reset word", word_o, 4'h0);
    chk("R11 async reset word clock", word_clk_o, 1'b0);
    chk("R11 async reset aux clock", aux_clk_o, 1'b0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule